// File: doc/BRIEF.md
# Prioritized serial interrupt identifier

This block merges the four interrupt causes of a serial channel into a single interrupt request line and an identification byte that the CPU reads to find which cause to service first. The causes are the receiver line errors, received data ready, transmit holding register empty and modem status change. Each cause is gated by its own bit in a small enable register. Only the most urgent enabled cause is reported. Lower causes stay hidden until the CPU services the one above them.

Three of the causes follow level flags that the surrounding channel logic drives. Those causes clear when the channel drops the flag, which happens after the CPU reads the line status, reads the received byte or reads the modem status. The transmit-empty cause is the only one this block remembers. A small state machine with two states holds it. `TXE_QUIET` means that no empty event is pending. `TXE_PEND` means an empty event is waiting for service. There are two transitions into `TXE_PEND`: the empty flag rises, or the transmit-empty enable is switched on while the flag is already high. There are two transitions back to `TXE_QUIET`: a write to the holding register, or a read of the identification byte that reports the transmit-empty cause. When a set and a clear fall in the same cycle, the clear wins.

Top module: `sir_intid`

## Requirements
- R1: When several enabled causes are pending at once, the identification byte reports only the highest one. The order from highest to lowest is line error, data ready, transmit empty, modem status.
- R2: The line-error cause is pending while any bit of `lsr_err` (overrun, parity, framing, break) is 1 and enable bit 2 is 1. It is never pending while enable bit 2 is 0.
- R3: The modem cause is pending while any bit of `msr_delta` is 1 and enable bit 3 is 1. It is never pending while enable bit 3 is 0.
- R4: The data-ready cause is pending while `rx_ready` is 1 and enable bit 0 is 1. The transmit-empty cause is pending while the transmit-empty state is `TXE_PEND` and enable bit 1 is 1.
- R5: Identification bit 0 is 0 when some cause is pending and 1 when none is pending. Bits [2:1] give the cause: 11 line error, 10 data ready, 01 transmit empty, 00 modem. Bits [7:3] read 0. The resulting values are 0x06, 0x04, 0x02 and 0x00 for the four causes, and 0x01 when nothing is pending.
- R6: `irq` is 1 exactly when at least one enabled cause is pending. It follows the flag inputs in the same cycle.
- R7: The transmit-empty state enters `TXE_PEND` at the clock edge where `thr_empty` is 1 and it was 0 at the previous edge. It also enters `TXE_PEND` at the edge where a write raises enable bit 1 while `thr_empty` is 1.
- R8: A read of the identification byte (`iid_rd`) that reports transmit empty returns the state to `TXE_QUIET` at that edge. A read that reports any other cause leaves the transmit-empty state unchanged.
- R9: A write to the holding register (`thr_wr`) returns the transmit-empty state to `TXE_QUIET` at that edge. It wins over a set event in the same cycle.
- R10: A write to the enable register takes effect at the clock edge. `ier_rdata` returns bits [3:0] as written and reads 0 in bits [7:4].
- R11: After reset the enable register is 0, the transmit-empty state is `TXE_QUIET`, the identification byte is 0x01 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Write data for the enable register |
| ier_rdata | output | 8 | Enable register read value |
| iid_rd | input | 1 | Read strobe for the identification byte |
| iid_data | output | 8 | Identification byte |
| thr_wr | input | 1 | Write strobe for the transmit holding register |
| lsr_err | input | 4 | Line error flags: overrun, parity, framing, break |
| rx_ready | input | 1 | Received data ready flag |
| thr_empty | input | 1 | Transmit holding register empty flag |
| msr_delta | input | 4 | Modem status change flags |
| irq | output | 1 | Interrupt request, active high |

## Verification
Changes to the flag inputs reach `iid_data` and `irq` in the same cycle. The bench drives the flags just after a rising edge and samples one time unit later, well before the next edge. A write to the enable register, a rising empty flag, a holding-register write or a servicing read only shows after the next rising edge, because each of these passes through one register. The bench therefore applies those strobes, waits for exactly one edge and samples just after it. A read strobe is sampled in the cycle it is asserted, which shows the value the CPU would capture, and it is checked again after the edge to see its clearing effect.

// File: rtl/sir_intid_pkg.sv
package sir_intid_pkg;

    typedef enum logic [1:0] {
        CAUSE_MODEM = 2'b00,
        CAUSE_TXE   = 2'b01,
        CAUSE_RXRDY = 2'b10,
        CAUSE_LINE  = 2'b11
    } cause_e;

    typedef enum logic {
        TXE_QUIET = 1'b0,
        TXE_PEND  = 1'b1
    } txe_state_e;

    localparam int EN_RXRDY = 0;
    localparam int EN_TXE   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_BITS  = 4;

endpackage

// File: rtl/sir_enable_reg.sv
module sir_enable_reg #(
    parameter int DW = 8,
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [EW-1:0] en,
    output logic [DW-1:0] rdata
);
    localparam int PADW = DW - EW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  en <= '0;
        else if (wr) en <= wdata[EW-1:0];
    end

    assign rdata = {{PADW{1'b0}}, en};

    AST_IER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (en == $past(wdata[EW-1:0]))); // R10
endmodule

// File: rtl/sir_txe_fsm.sv
module sir_txe_fsm
    import sir_intid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty,
    input  logic arm,
    input  logic clr_wr,
    input  logic clr_rd,
    output logic pend
);
    txe_state_e state, state_nx;
    logic       empty_q;
    logic       rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) empty_q <= 1'b0;
        else        empty_q <= empty;
    end

    assign rise = empty & ~empty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXE_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TXE_QUIET: if (!clr_wr && (rise || arm)) state_nx = TXE_PEND;
            TXE_PEND:  if (clr_wr || clr_rd)         state_nx = TXE_QUIET;
            default:   state_nx = TXE_QUIET;
        endcase
    end

    always_comb begin
        unique case (state)
            TXE_PEND: pend = 1'b1;
            default:  pend = 1'b0;
        endcase
    end

    AST_TXE_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !pend); // R9
    AST_TXE_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !clr_wr && !clr_rd) |=> pend); // R7
endmodule

// File: rtl/sir_prio_enc.sv
module sir_prio_enc
    import sir_intid_pkg::*;
#(
    parameter int EW  = 4,
    parameter int ERW = 4,
    parameter int MDW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EW-1:0]  en,
    input  logic [ERW-1:0] err,
    input  logic           rx_ready,
    input  logic           txe_pend,
    input  logic [MDW-1:0] delta,
    output logic           pend_n,
    output cause_e         cause
);
    logic line_act, rx_act, txe_act, mdm_act;

    assign line_act = en[EN_LINE]  & (|err);
    assign rx_act   = en[EN_RXRDY] & rx_ready;
    assign txe_act  = en[EN_TXE]   & txe_pend;
    assign mdm_act  = en[EN_MODEM] & (|delta);

    always_comb begin
        pend_n = 1'b0;
        if (line_act)     cause = CAUSE_LINE;
        else if (rx_act)  cause = CAUSE_RXRDY;
        else if (txe_act) cause = CAUSE_TXE;
        else if (mdm_act) cause = CAUSE_MODEM;
        else begin
            cause  = CAUSE_MODEM;
            pend_n = 1'b1;
        end
    end

    AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en[EN_LINE] && (|err)) |-> (!pend_n && cause == CAUSE_LINE)); // R1
    AST_MODEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[EN_MODEM] && cause == CAUSE_MODEM) |-> pend_n); // R3
endmodule

// File: rtl/sir_intid.sv
module sir_intid
    import sir_intid_pkg::*;
#(
    parameter int DW  = 8,
    parameter int ERW = 4,
    parameter int MDW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ier_wr,
    input  logic [DW-1:0]  ier_wdata,
    output logic [DW-1:0]  ier_rdata,
    input  logic           iid_rd,
    output logic [DW-1:0]  iid_data,
    input  logic           thr_wr,
    input  logic [ERW-1:0] lsr_err,
    input  logic           rx_ready,
    input  logic           thr_empty,
    input  logic [MDW-1:0] msr_delta,
    output logic           irq
);
    localparam int EW   = EN_BITS;
    localparam int PADW = DW - 3;

    logic [EW-1:0] en;
    logic          txe_pend, pend_n, arm, rd_txe;
    cause_e        cause;

    sir_enable_reg #(.DW(DW), .EW(EW)) u_en (
        .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
        .en(en), .rdata(ier_rdata)
    );

    assign arm    = ier_wr & ier_wdata[EN_TXE] & ~en[EN_TXE] & thr_empty;
    assign rd_txe = iid_rd & ~pend_n & (cause == CAUSE_TXE);

    sir_txe_fsm u_txe (
        .clk(clk), .rst_n(rst_n), .empty(thr_empty), .arm(arm),
        .clr_wr(thr_wr), .clr_rd(rd_txe), .pend(txe_pend)
    );

    sir_prio_enc #(.EW(EW), .ERW(ERW), .MDW(MDW)) u_prio (
        .clk(clk), .rst_n(rst_n), .en(en), .err(lsr_err),
        .rx_ready(rx_ready), .txe_pend(txe_pend), .delta(msr_delta),
        .pend_n(pend_n), .cause(cause)
    );

    assign iid_data = {{(PADW){1'b0}}, cause, pend_n};
    assign irq      = ~pend_n;

    AST_RD_OTHER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd && !thr_wr && txe_pend && cause != CAUSE_TXE) |=> txe_pend); // R8
    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[EN_RXRDY] && !pend_n) |-> (cause != CAUSE_RXRDY)); // R4
endmodule

// File: tb/sir_intid_test.sv
module sir_intid_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 1'b0;
    logic [7:0] ier_wdata = '0;
    logic [7:0] ier_rdata;
    logic       iid_rd = 1'b0;
    logic [7:0] iid_data;
    logic       thr_wr = 1'b0;
    logic [3:0] lsr_err = '0;
    logic       rx_ready = 1'b0;
    logic       thr_empty = 1'b0;
    logic [3:0] msr_delta = '0;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sir_intid uut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .ier_rdata(ier_rdata), .iid_rd(iid_rd), .iid_data(iid_data),
        .thr_wr(thr_wr), .lsr_err(lsr_err), .rx_ready(rx_ready),
        .thr_empty(thr_empty), .msr_delta(msr_delta), .irq(irq)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] model(input logic [3:0] en, input logic line,
                                         input logic rx, input logic txp, input logic md);
        if (en[2] && line)     return 8'h06;
        else if (en[0] && rx)  return 8'h04;
        else if (en[1] && txp) return 8'h02;
        else if (en[3] && md)  return 8'h00;
        else                   return 8'h01;
    endfunction

    task automatic write_ier(input logic [7:0] v);
        ier_wr = 1'b1; ier_wdata = v;
        tick;
        ier_wr = 1'b0;
    endtask

    task automatic pulse_thr_wr;
        thr_wr = 1'b1;
        tick;
        thr_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] e;
        #3;
        // R11 reset state
        check8("R11 iid", iid_data, 8'h01);
        check8("R11 irq", {7'b0, irq}, 8'h00);
        check8("R11 ier", ier_rdata, 8'h00);
        tick;
        rst_n = 1'b1;
        tick;
        check8("R11 iid after release", iid_data, 8'h01);

        // R10 enable readback
        write_ier(8'hFF);
        check8("R10 ier upper zero", ier_rdata, 8'h0F);
        write_ier(8'hA5);
        check8("R10 ier 5", ier_rdata, 8'h05);

        // Sweep: every enable value against every cause combination (R1-style priority)
        for (int en = 0; en < 16; en++) begin
            for (int c = 0; c < 16; c++) begin
                thr_empty = 1'b0; lsr_err = '0; rx_ready = 1'b0; msr_delta = '0;
                pulse_thr_wr;
                write_ier(8'(en));
                if (c[2]) begin
                    thr_empty = 1'b1;
                    tick;
                end
                lsr_err   = c[0] ? 4'(1 << ((en + c) % 4)) : 4'h0;
                rx_ready  = c[1];
                msr_delta = c[3] ? 4'(1 << ((en * 3 + c) % 4)) : 4'h0;
                #1;
                e = model(4'(en), c[0], c[1], c[2], c[3]);
                check8("R1 R2 R3 R4 R5 iid", iid_data, e);
                check8("R6 irq", {7'b0, irq}, {7'b0, ~e[0]});
                tick;
            end
        end
        lsr_err = '0; rx_ready = 1'b0; msr_delta = '0; thr_empty = 1'b0;
        pulse_thr_wr;

        // R7 rise sets pending only after the edge
        write_ier(8'h02);
        thr_empty = 1'b1;
        #1;
        check8("R7 before edge", iid_data, 8'h01);
        tick;
        check8("R7 after rise", iid_data, 8'h02);

        // R8 read reporting a higher cause keeps transmit empty
        write_ier(8'h06);
        lsr_err = 4'h8;
        #1;
        iid_rd = 1'b1;
        #1;
        check8("R8 read sees line", iid_data, 8'h06);
        tick;
        iid_rd = 1'b0;
        lsr_err = '0;
        #1;
        check8("R8 txe survives", iid_data, 8'h02);
        // R8 read reporting transmit empty clears it
        iid_rd = 1'b1;
        #1;
        check8("R8 read sees txe", iid_data, 8'h02);
        tick;
        iid_rd = 1'b0;
        check8("R8 cleared by read", iid_data, 8'h01);
        check8("R8 irq low", {7'b0, irq}, 8'h00);

        // R7 enabling while empty sets pending
        write_ier(8'h00);
        check8("R7 disabled", iid_data, 8'h01);
        write_ier(8'h02);
        check8("R7 arm on enable", iid_data, 8'h02);

        // R9 holding write clears
        pulse_thr_wr;
        check8("R9 cleared by write", iid_data, 8'h01);
        // R9 write wins over simultaneous rise
        thr_empty = 1'b0;
        tick;
        thr_empty = 1'b1; thr_wr = 1'b1;
        tick;
        thr_wr = 1'b0;
        check8("R9 write beats rise", iid_data, 8'h01);
        tick;
        check8("R9 no late set", iid_data, 8'h01);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule